// File: doc/BRIEF.md
# Dual-Lane Link Lock Supervisor

This block supervises receive-side lock for a serial link that carries its payload over two lanes, each with an embedded clock marker. Every clock cycle is one frame. For each lane the front end reports whether the marker was seen in that frame. It also reports the measured phase offset of lane 1 against lane 0, as a signed count in tenths of a frame period. The supervisor first qualifies the master lane (lane 0). Only then does it qualify and align the secondary lane (lane 1). After both lanes pass, it raises the lock status.

While lock is high, the 32-bit parallel word is registered to the output and the recovered-clock enable is allowed. When a single frame misses its marker on either lane, lock drops and acquisition restarts on the master lane. No training pattern is needed. A receive-enable input and an active-low powerdown input control the output enable of the data and clock outputs. The lock status output stays driven whatever the output enable is. Pulling powerdown low clears all lock progress.

Top module: `link_lock_ctrl`

## Requirements
- R1: After synchronous reset, lock is 0, the data output is 0 and the recovered-clock enable is 0.
- R2: Lane 0 counts as qualified only after LOCK_FRAMES (default 4) consecutive frames with its marker. A frame without the marker restarts the count.
- R3: Lane 1 frames do not count toward lock until lane 0 is qualified. Lane 1 qualification needs another LOCK_FRAMES consecutive good frames, so lock rises no earlier than 2*LOCK_FRAMES+1 clock edges after powerdown is released.
- R4: Lock rises only from lane 1 qualification, at the edge of the LOCK_FRAMES-th consecutive frame in which both markers are seen and the skew is within tolerance.
- R5: The skew is treated as a two's-complement value. Values from -4 to +4 are accepted. A value outside that range restarts the lane 1 count. -16 is rejected.
- R6: While locked, a frame that misses the marker on either lane clears lock at that edge. Acquisition then restarts on lane 0.
- R7: A lane 0 miss during lane 1 qualification sends acquisition back to lane 0 with its count cleared.
- R8: The output enable equals rx_en AND pd_n and does not depend on lock. Lock stays driven and unchanged when rx_en is low.
- R9: The recovered-clock enable is high exactly when lock and the output enable are both high.
- R10: With pd_n low, the next edge clears lock and all progress. After pd_n returns high, the full sequence of R3 is needed again.
- R11: The data output takes data_in at each edge that keeps lock. At any other edge it holds its value, including the edge where lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low powerdown |
| rx_en | input | 1 | Receive output enable |
| lane0_mark | input | 1 | Lane 0 embedded clock seen this frame |
| lane1_mark | input | 1 | Lane 1 embedded clock seen this frame |
| lane_skew | input | 5 | Signed lane 1 phase offset, tenths of a period |
| data_in | input | 32 | Deserialized parallel word |
| data_out | output | 32 | Registered parallel word |
| out_oe | output | 1 | Enable for data and recovered-clock drivers |
| rclk_en | output | 1 | Recovered clock enable |
| lock | output | 1 | Link lock status |

## Verification
A wrong acquisition state shows up as lock rising one or more edges early or late. So the bench counts edges from the release of powerdown or from the last miss, and it checks lock on the exact edge where it must first rise and on the edge just before. A stale count or a missing restart after a miss shows up as early lock within at most 2*LOCK_FRAMES frames. A bad capture condition shows up on data_out on the very edge that loses lock, and again on later unlocked frames.

// File: rtl/link_lock_ctrl.sv
module link_lock_ctrl #(
  parameter int DATA_W      = 32,
  parameter int LOCK_FRAMES = 4,
  parameter int SKEW_W      = 5,
  parameter int SKEW_TOL    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pd_n,
  input  logic                     rx_en,
  input  logic                     lane0_mark,
  input  logic                     lane1_mark,
  input  logic signed [SKEW_W-1:0] lane_skew,
  input  logic [DATA_W-1:0]        data_in,
  output logic [DATA_W-1:0]        data_out,
  output logic                     out_oe,
  output logic                     rclk_en,
  output logic                     lock
);
  localparam int CW = $clog2(LOCK_FRAMES + 1);

  typedef enum logic [1:0] {S_PD, S_MASTER, S_SLAVE, S_LOCKED} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [SKEW_W-1:0] skew_mag;
  logic          skew_ok, cnt_done, both_ok;

  assign skew_mag = lane_skew[SKEW_W-1] ? SKEW_W'(-lane_skew) : SKEW_W'(lane_skew);
  assign skew_ok  = skew_mag <= SKEW_W'(SKEW_TOL);
  assign cnt_done = cnt == CW'(LOCK_FRAMES - 1);
  assign both_ok  = lane0_mark && lane1_mark;

  always_comb begin
    st_nx  = st;
    cnt_nx = '0;
    case (st)
      S_PD: st_nx = S_MASTER;
      S_MASTER:
        if (lane0_mark) begin
          if (cnt_done) st_nx = S_SLAVE;
          else          cnt_nx = cnt + 1'b1;
        end
      S_SLAVE:
        if (!lane0_mark) st_nx = S_MASTER;
        else if (lane1_mark && skew_ok) begin
          if (cnt_done) st_nx = S_LOCKED;
          else          cnt_nx = cnt + 1'b1;
        end
      S_LOCKED:
        if (!both_ok) st_nx = S_MASTER;
      default: st_nx = S_PD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pd_n) begin
      st  <= S_PD;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    data_out <= '0;
    else if (pd_n && st == S_LOCKED && both_ok)    data_out <= data_in;
  end

  assign lock    = st == S_LOCKED;
  assign out_oe  = rx_en & pd_n;
  assign rclk_en = lock & out_oe;

  assert_lock_from_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(st) == S_SLAVE);

  assert_master_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SLAVE |-> ($past(st) == S_MASTER || $past(st) == S_SLAVE));

  assert_miss_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && pd_n && !(lane0_mark && lane1_mark)) |=> st == S_MASTER);

  assert_pd_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (st == S_PD && cnt == '0 && !lock));

  assert_hold_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> $stable(data_out));

  assert_skew_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && st == S_SLAVE && lane0_mark &&
     ($signed(lane_skew) > SKEW_TOL || $signed(lane_skew) < -SKEW_TOL))
    |=> (st == S_SLAVE && cnt == '0));
endmodule

// File: tb/link_lock_ctrl_bench.sv
module link_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pd_n = 1'b1, rx_en = 1'b1, l0 = 1'b0, l1 = 1'b0;
  logic signed [4:0] skew = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic oe, rclk, lock;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  link_lock_ctrl u_link_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .rx_en(rx_en),
    .lane0_mark(l0), .lane1_mark(l1), .lane_skew(skew), .data_in(din),
    .data_out(dout), .out_oe(oe), .rclk_en(rclk), .lock(lock));

  // {pd_n, rx_en, lane0, lane1, skew[4:0], expected lock after the edge}
  localparam logic [9:0] VEC [29] = '{
    10'b1_1_1_1_00000_0, // 0 leave PD
    10'b1_1_1_1_00000_0, // 1 lane0 count, lane1 ignored R3
    10'b1_1_1_1_00000_0, // 2
    10'b1_1_1_1_00000_0, // 3
    10'b1_1_0_1_00000_0, // 4 lane0 miss restarts count R2
    10'b1_1_1_0_00000_0, // 5
    10'b1_1_1_0_00000_0, // 6
    10'b1_1_1_0_00000_0, // 7
    10'b1_1_1_0_00000_0, // 8 lane0 qualified
    10'b1_1_1_1_00101_0, // 9 skew +5 rejected R5
    10'b1_1_1_1_11100_0, // 10 skew -4 ok
    10'b1_1_1_1_00100_0, // 11 skew +4 ok
    10'b1_1_1_1_00000_0, // 12
    10'b1_1_1_1_11011_0, // 13 skew -5 rejected R5
    10'b1_1_1_1_00000_0, // 14
    10'b1_1_1_1_00000_0, // 15
    10'b1_1_1_1_00000_0, // 16
    10'b1_1_1_1_00000_1, // 17 lock R4
    10'b1_0_1_1_00000_1, // 18 rx_en low, lock stays R8
    10'b1_1_1_0_00000_0, // 19 lane1 miss drops R6
    10'b1_1_1_0_00000_0, // 20
    10'b1_1_1_0_00000_0, // 21
    10'b1_1_1_0_00000_0, // 22
    10'b1_1_1_0_00000_0, // 23 lane0 qualified again
    10'b1_1_1_1_00000_0, // 24
    10'b1_1_1_1_00000_0, // 25
    10'b1_1_1_1_00000_0, // 26
    10'b1_1_1_1_00000_1, // 27 relocked
    10'b1_1_0_1_00000_0  // 28 lane0 miss drops R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic p, input logic e, input logic a, input logic b,
                       input logic [4:0] s, input logic [31:0] d);
    @(negedge clk);
    pd_n = p; rx_en = e; l0 = a; l1 = b; skew = s; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic good(input int n);
    for (int k = 0; k < n; k++) frame(1, 1, 1, 1, 5'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 lock", {31'd0, lock}, 32'd0);
    chk("R1 data", dout, 32'd0);
    chk("R1 rclk", {31'd0, rclk}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 29; i++) begin
      frame(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:1], 32'hA500_0000 | i);
      chk($sformatf("R2 R3 R4 R5 R6 lock v%0d", i), {31'd0, lock}, {31'd0, VEC[i][0]});
      chk($sformatf("R8 oe v%0d", i), {31'd0, oe}, {31'd0, VEC[i][9] & VEC[i][8]});
      chk($sformatf("R9 rclk v%0d", i), {31'd0, rclk},
          {31'd0, VEC[i][0] & VEC[i][9] & VEC[i][8]});
    end

    // R7: lane0 miss while qualifying lane1
    good(4);
    good(2);
    frame(1, 1, 0, 1, 5'd0, 32'h0);
    good(7);
    chk("R7 early", {31'd0, lock}, 32'd0);
    good(1);
    chk("R7 lock", {31'd0, lock}, 32'd1);

    // R11: capture while locked, hold on loss
    frame(1, 1, 1, 1, 5'd0, 32'h1234_5678);
    chk("R11 capture", dout, 32'h1234_5678);
    frame(1, 1, 1, 0, 5'd0, 32'hDEAD_BEEF);
    chk("R11 loss edge", dout, 32'h1234_5678);
    frame(1, 1, 1, 1, 5'd0, 32'hCAFE_0001);
    chk("R11 unlocked hold", dout, 32'h1234_5678);

    // R5: most negative skew rejected
    good(3);
    frame(1, 1, 1, 1, 5'b10000, 32'h0);
    good(3);
    chk("R5 -16 rejected", {31'd0, lock}, 32'd0);
    good(1);
    chk("R5 lock after -16", {31'd0, lock}, 32'd1);

    // R10: powerdown clears, full sequence needed
    @(negedge clk);
    pd_n = 1'b0;
    #1;
    chk("R8 oe pd", {31'd0, oe}, 32'd0);
    chk("R9 rclk pd", {31'd0, rclk}, 32'd0);
    @(posedge clk);
    #1;
    chk("R10 pd clears", {31'd0, lock}, 32'd0);
    good(8);
    chk("R10 early", {31'd0, lock}, 32'd0);
    good(1);
    chk("R10 relock", {31'd0, lock}, 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule